// File: doc/BRIEF.md
# Overflow Flag Multiplexer with Shared Timeout

This block turns short overrange strobes from a left and a right converter channel into one active-low overflow line. Each strobe sets its channel's flag at once, and the flag then holds for a programmable number of frame-clock periods. Both flags share a single timeout counter. A strobe on either channel reloads that counter, so a burst of overranges on one side also keeps the other side's flag alive. When the counter runs out, both flags clear together.

The line carries the two flags in turn, following the phase of the frame clock. The block samples the serial bit clock and the frame clock in the system clock domain. A rising bit-clock edge is the bit tick. A frame transition is noticed on the first bit tick that sees the new frame level. The channel shown on the line switches a fixed number of bit ticks after that tick: one in left-justified format and two in I2S format. Downstream logic can therefore latch each channel's status on a frame clock edge.

Two state machines do the work. The hold machine (states HOLD_IDLE and HOLD_ACTIVE) owns the flags and the counter. Its transitions are: ARM, from HOLD_IDLE to HOLD_ACTIVE on any strobe; RELOAD, a strobe while in HOLD_ACTIVE; and EXPIRE, the last frame period, from HOLD_ACTIVE back to HOLD_IDLE. The alignment machine (states ALN_WAIT and ALN_DELAY) owns the displayed channel. Its transitions are: START, on a frame transition, from ALN_WAIT to ALN_DELAY, or a restart while in ALN_DELAY; and COMMIT, on the bit tick where the lag is reached, from ALN_DELAY back to ALN_WAIT.

Top module: `ovf_flag_mux`

## Requirements
- R1: After reset both flags are inactive and `ovfl_n_o` is 1. While both flags are inactive, `ovfl_n_o` stays 1.
- R2: A one-cycle strobe on `ovr_left_i` or `ovr_right_i` sets that channel's flag at the next clock edge. `ovfl_n_o` goes to 0 one cycle later if that channel is the one currently displayed.
- R3: A flag stays set until TIMEOUT_FRAMES rising frame transitions, as seen at bit ticks, have passed since the last strobe. On the last of these, both flags clear together and `ovfl_n_o` returns to 1.
- R4: A strobe on either channel reloads the shared counter to TIMEOUT_FRAMES. This extends the hold time of both flags, including a flag set earlier by the other channel.
- R5: With `fmt_i2s_i`=0 (left-justified), the left flag is displayed while `frame_i`=1 and the right flag while `frame_i`=0. The displayed value is the inverse of the flag (0 means flag set).
- R6: With `fmt_i2s_i`=1 (I2S), the left flag is displayed while `frame_i`=0 and the right flag while `frame_i`=1.
- R7: A bit tick is a rising edge of `bclk_i`. In left-justified format, the displayed channel changes on the first bit tick after the tick where the new frame level is first seen.
- R8: In I2S format, the displayed channel changes on the second bit tick after the tick where the new frame level is first seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, sampled as a level |
| frame_i | input | 1 | Frame clock giving the channel phase |
| fmt_i2s_i | input | 1 | 0 = left-justified, 1 = I2S; taken at each frame transition |
| ovr_left_i | input | 1 | One-cycle overrange strobe, left channel |
| ovr_right_i | input | 1 | One-cycle overrange strobe, right channel |
| ovfl_n_o | output | 1 | Multiplexed overflow line, low while the displayed flag is set |

## Verification
The bench samples the line one bit before and one bit after the point where the displayed channel should switch. A design that switched on the wrong tick, or used the left-justified lag in I2S mode, would show the previous half-frame's channel in the wrong bit slot. One scenario strobes the left channel and then the right channel some frames later. Left must stay low past its own timeout, because a design with separate counters would release it early. Both the end of the hold and the reversed channel map in I2S mode are checked bit by bit. A design with an off-by-one count would clear a frame too early or too late, and one with a swapped map would show the wrong side's flag in each half.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef enum logic {
        HOLD_IDLE   = 1'b0,
        HOLD_ACTIVE = 1'b1
    } hold_state_e;

    typedef enum logic {
        ALN_WAIT  = 1'b0,
        ALN_DELAY = 1'b1
    } aln_state_e;

    // Channel carried during a frame half, given its level and the format
    function automatic chan_e slot_chan(input logic lvl, input logic i2s);
        if (i2s) begin
            slot_chan = lvl ? CH_RIGHT : CH_LEFT;
        end else begin
            slot_chan = lvl ? CH_LEFT : CH_RIGHT;
        end
    endfunction

endpackage

// File: rtl/ovf_bit_edge.sv
module ovf_bit_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic frame_i,
    output logic bit_tick,
    output logic frame_lvl,
    output logic frame_edge,
    output logic frame_rise
);

    logic bclk_s;
    logic bclk_d;
    logic frame_s;
    logic frame_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_s  <= 1'b0;
            bclk_d  <= 1'b0;
            frame_s <= 1'b0;
        end else begin
            bclk_s  <= bclk_i;
            bclk_d  <= bclk_s;
            frame_s <= frame_i;
        end
    end

    // Level of the frame clock seen at the previous bit tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_last <= 1'b0;
        end else if (bit_tick) begin
            frame_last <= frame_s;
        end
    end

    always_comb begin
        bit_tick   = bclk_s & ~bclk_d;
        frame_lvl  = frame_s;
        frame_edge = bit_tick & (frame_s ^ frame_last);
        frame_rise = frame_edge & frame_s;
    end

endmodule

// File: rtl/ovf_flag_hold.sv
module ovf_flag_hold
    import ovf_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 64,
    parameter int CNT_W          = $clog2(TIMEOUT_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_left,
    input  logic             ovr_right,
    input  logic             frame_rise,
    output logic             flag_left,
    output logic             flag_right,
    output logic [CNT_W-1:0] tmo_cnt
);

    localparam int NUM_CH = 2;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_FRAMES);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    hold_state_e       state_q;
    hold_state_e       state_d;
    logic [NUM_CH-1:0] ovr_v;
    logic [NUM_CH-1:0] flag_v;
    logic              any_ovr;
    logic              last_period;
    logic              do_arm;
    logic              do_reload;
    logic              do_expire;
    logic              do_count;

    always_comb begin
        ovr_v       = {ovr_right, ovr_left};
        any_ovr     = |ovr_v;
        last_period = frame_rise && (tmo_cnt == ONE);
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_IDLE: begin
                if (any_ovr) begin
                    state_d = HOLD_ACTIVE;   // ARM
                end
            end
            HOLD_ACTIVE: begin
                if (!any_ovr && last_period) begin
                    state_d = HOLD_IDLE;     // EXPIRE
                end
            end
            default: state_d = HOLD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Action decode
    always_comb begin
        do_arm    = 1'b0;
        do_reload = 1'b0;
        do_expire = 1'b0;
        do_count  = 1'b0;
        unique case (state_q)
            HOLD_IDLE: begin
                do_arm = any_ovr;
            end
            HOLD_ACTIVE: begin
                do_reload = any_ovr;
                do_expire = !any_ovr && last_period;
                do_count  = !any_ovr && frame_rise && !last_period;
            end
            default: ;
        endcase
    end

    // Shared counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_cnt <= '0;
        end else if (do_arm || do_reload) begin
            tmo_cnt <= RELOAD;
        end else if (do_expire) begin
            tmo_cnt <= '0;
        end else if (do_count) begin
            tmo_cnt <= tmo_cnt - ONE;
        end
    end

    // One flag register per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_v[ch] <= 1'b0;
            end else if (ovr_v[ch]) begin
                flag_v[ch] <= 1'b1;
            end else if (do_expire) begin
                flag_v[ch] <= 1'b0;
            end
        end
    end

    always_comb begin
        flag_left  = flag_v[0];
        flag_right = flag_v[1];
    end

endmodule

// File: rtl/ovf_slot_align.sv
module ovf_slot_align
    import ovf_pkg::*;
#(
    parameter int LJ_LAG  = 1,
    parameter int I2S_LAG = 2,
    parameter int LAG_W   = $clog2(((LJ_LAG > I2S_LAG) ? LJ_LAG : I2S_LAG) + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_tick,
    input  logic  frame_edge,
    input  logic  frame_lvl,
    input  logic  fmt_i2s,
    output chan_e shown_ch
);

    localparam logic [LAG_W-1:0] LAG_LJ  = LAG_W'(LJ_LAG);
    localparam logic [LAG_W-1:0] LAG_I2S = LAG_W'(I2S_LAG);
    localparam logic [LAG_W-1:0] ONE     = LAG_W'(1);

    aln_state_e       state_q;
    aln_state_e       state_d;
    chan_e            pend_ch;
    logic [LAG_W-1:0] lag_q;
    logic [LAG_W-1:0] tick_cnt;
    logic             do_start;
    logic             do_commit;
    logic             do_step;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALN_WAIT: begin
                if (frame_edge) begin
                    state_d = ALN_DELAY;     // START
                end
            end
            ALN_DELAY: begin
                if (frame_edge) begin
                    state_d = ALN_DELAY;     // START again
                end else if (bit_tick && (tick_cnt == lag_q)) begin
                    state_d = ALN_WAIT;      // COMMIT
                end
            end
            default: state_d = ALN_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALN_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Action decode
    always_comb begin
        do_start  = frame_edge;
        do_commit = 1'b0;
        do_step   = 1'b0;
        unique case (state_q)
            ALN_WAIT: ;
            ALN_DELAY: begin
                do_commit = !frame_edge && bit_tick && (tick_cnt == lag_q);
                do_step   = !frame_edge && bit_tick && (tick_cnt != lag_q);
            end
            default: ;
        endcase
    end

    // Pending channel, lag and tick count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_ch  <= CH_LEFT;
            lag_q    <= LAG_LJ;
            tick_cnt <= '0;
        end else if (do_start) begin
            pend_ch  <= slot_chan(frame_lvl, fmt_i2s);
            lag_q    <= fmt_i2s ? LAG_I2S : LAG_LJ;
            tick_cnt <= ONE;
        end else if (do_step) begin
            tick_cnt <= tick_cnt + ONE;
        end
    end

    // Displayed channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shown_ch <= CH_LEFT;
        end else if (do_commit) begin
            shown_ch <= pend_ch;
        end
    end

endmodule

// File: rtl/ovf_flag_mux.sv
module ovf_flag_mux
    import ovf_pkg::*;
#(
    parameter int TIMEOUT_FRAMES = 64,
    parameter int LJ_LAG         = 1,
    parameter int I2S_LAG        = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic frame_i,
    input  logic fmt_i2s_i,
    input  logic ovr_left_i,
    input  logic ovr_right_i,
    output logic ovfl_n_o
);

    localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);

    logic             bit_tick;
    logic             frame_lvl;
    logic             frame_edge;
    logic             frame_rise;
    logic             flag_left;
    logic             flag_right;
    logic [CNT_W-1:0] tmo_cnt;
    chan_e            shown_ch;
    logic             shown_flag;

    ovf_bit_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_i     (bclk_i),
        .frame_i    (frame_i),
        .bit_tick   (bit_tick),
        .frame_lvl  (frame_lvl),
        .frame_edge (frame_edge),
        .frame_rise (frame_rise)
    );

    ovf_flag_hold #(
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES),
        .CNT_W          (CNT_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovr_left   (ovr_left_i),
        .ovr_right  (ovr_right_i),
        .frame_rise (frame_rise),
        .flag_left  (flag_left),
        .flag_right (flag_right),
        .tmo_cnt    (tmo_cnt)
    );

    ovf_slot_align #(
        .LJ_LAG  (LJ_LAG),
        .I2S_LAG (I2S_LAG)
    ) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_edge (frame_edge),
        .frame_lvl  (frame_lvl),
        .fmt_i2s    (fmt_i2s_i),
        .shown_ch   (shown_ch)
    );

    always_comb begin
        unique case (shown_ch)
            CH_LEFT:  shown_flag = flag_left;
            CH_RIGHT: shown_flag = flag_right;
            default:  shown_flag = 1'b0;
        endcase
    end

    // Registered active-low line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovfl_n_o <= 1'b1;
        end else begin
            ovfl_n_o <= ~shown_flag;
        end
    end

endmodule

// File: rtl/ovf_flag_mux_chk.sv
module ovf_flag_mux_chk #(
    parameter int TIMEOUT_FRAMES = 64,
    parameter int CNT_W          = $clog2(TIMEOUT_FRAMES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ovr_left_i,
    input logic             ovr_right_i,
    input logic             ovfl_n_o,
    input logic             flag_l,
    input logic             flag_r,
    input logic [CNT_W-1:0] tmo_cnt,
    input logic             shown,
    input logic             bit_tick,
    input logic             frame_rise
);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_l && !flag_r) |=> ovfl_n_o);

    assert_set_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_left_i |=> flag_l);

    assert_set_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_right_i |=> flag_r);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_l || flag_r) && !frame_rise) |=> ($stable(flag_l) || flag_l) && ($stable(flag_r) || flag_r));

    assert_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_left_i && !ovr_right_i && frame_rise && tmo_cnt == CNT_W'(1)) |=> (!flag_l && !flag_r));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_left_i || ovr_right_i) |=> (tmo_cnt == CNT_W'(TIMEOUT_FRAMES)));

    assert_shown_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(shown));

endmodule

bind ovf_flag_mux ovf_flag_mux_chk #(
    .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovr_left_i  (ovr_left_i),
    .ovr_right_i (ovr_right_i),
    .ovfl_n_o    (ovfl_n_o),
    .flag_l      (flag_left),
    .flag_r      (flag_right),
    .tmo_cnt     (tmo_cnt),
    .shown       (shown_ch),
    .bit_tick    (bit_tick),
    .frame_rise  (frame_rise)
);

// File: tb/ovf_flag_mux_test.sv
module ovf_flag_mux_test;

    localparam int TMO       = 64;
    localparam int HALF_BITS = 8;
    localparam int LEFT      = 0;
    localparam int RIGHT     = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b1;
    logic frame = 1'b0;
    logic fmt_i2s = 1'b0;
    logic ovr_l = 1'b0;
    logic ovr_r = 1'b0;
    logic ovfl_n;

    always #2 clk = ~clk;

    ovf_flag_mux #(.TIMEOUT_FRAMES(TMO)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk),
        .frame_i     (frame),
        .fmt_i2s_i   (fmt_i2s),
        .ovr_left_i  (ovr_l),
        .ovr_right_i (ovr_r),
        .ovfl_n_o    (ovfl_n)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb[$];
    event  chk_ev;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Reference model state
    logic  m_fl_l = 1'b0;
    logic  m_fl_r = 1'b0;
    int    m_tmo = 0;
    int    m_shown = LEFT;
    bit    m_i2s = 0;
    string cur_tag = "R1";

    function automatic int chan_of(input bit lvl, input bit i2s);
        if (i2s) return lvl ? RIGHT : LEFT;
        return lvl ? LEFT : RIGHT;
    endfunction

    function automatic logic exp_line(input int ch);
        return (ch == LEFT) ? ~m_fl_l : ~m_fl_r;
    endfunction

    task automatic push(input logic e, input string t);
        item_t it;
        it.exp = e;
        it.tag = t;
        sb.push_back(it);
        -> chk_ev;
    endtask

    // Monitor: pops one expected item per sample point
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (ovfl_n !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: ovfl_n actual %b expected %b at %0t",
                             it.tag, ovfl_n, it.exp, $time);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // One frame half of HALF_BITS bits; sl/sr give the bit of a strobe (-1 none)
    task automatic run_half(input bit lvl, input int sl, input int sr);
        int    pend;
        int    lag;
        string lag_tag;
        pend    = chan_of(lvl, m_i2s);
        lag     = m_i2s ? 2 : 1;
        lag_tag = m_i2s ? "R8" : "R7";
        for (int k = 0; k < HALF_BITS; k++) begin
            bclk = 1'b0;
            if (k == 0) frame = lvl;
            step(2);
            begin
                int ch;
                ch = (k >= lag + 1) ? pend : m_shown;
                push(exp_line(ch), (k >= 1 && k <= lag + 1) ? lag_tag : cur_tag);
            end
            step(6);
            bclk = 1'b1;
            if (k == 0 && lvl && m_tmo > 0) begin
                m_tmo--;
                if (m_tmo == 0) begin
                    m_fl_l = 1'b0;
                    m_fl_r = 1'b0;
                end
            end
            step(4);
            if (sl == k || sr == k) begin
                ovr_l = (sl == k);
                ovr_r = (sr == k);
                if (sl == k) m_fl_l = 1'b1;
                if (sr == k) m_fl_r = 1'b1;
                m_tmo = TMO;
                step(1);
                ovr_l = 1'b0;
                ovr_r = 1'b0;
                step(2);
                // R2: flag visible right away when its channel is displayed
                push(exp_line((k >= lag) ? pend : m_shown), "R2");
                step(1);
            end else begin
                step(4);
            end
        end
        m_shown = pend;
    endtask

    task automatic run_frames(input int n);
        for (int f = 0; f < n; f++) begin
            run_half(1'b1, -1, -1);
            run_half(1'b0, -1, -1);
        end
    endtask

    initial begin
        step(6);
        rst_n = 1'b1;
        step(2);
        push(1'b1, "R1");   // R1 reset state

        // Left-justified, no overrange
        cur_tag = "R1";
        run_frames(2);

        // R5: left strobe while left is displayed
        cur_tag = "R5";
        run_half(1'b1, 4, -1);
        run_half(1'b0, -1, -1);
        run_frames(10);

        // R4: right strobe keeps left alive past its own timeout
        cur_tag = "R4";
        run_half(1'b1, -1, -1);
        run_half(1'b0, -1, 3);
        run_frames(60);

        // R3: shared expiry
        cur_tag = "R3";
        run_frames(10);

        // R6: I2S mapping and lag
        fmt_i2s = 1'b1;
        m_i2s   = 1;
        cur_tag = "R6";
        run_half(1'b1, -1, -1);
        run_half(1'b0, 5, -1);
        run_half(1'b1, -1, 6);
        run_half(1'b0, -1, -1);
        run_frames(4);

        cur_tag = "R3";
        run_frames(66);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule